// File: doc/BRIEF.md
# Byte-Accessed Seconds Counter

This peripheral keeps a free-running seconds count that software reaches over a narrow register bus. The bus has an 8-bit address, a write strobe with write data and a read strobe with read data, all one byte wide. A tick input pulses once per second and advances the count, but only while the enable bit in the control register is set. The full count is also driven out of the block so that a neighbouring alarm unit can compare against it.

To set the time, software writes the value into a bank of staging byte registers. Writing the upper staging bytes never disturbs the running count. Writing the lowest staging byte moves the whole value into the counter in one cycle. The usual sequence is: write zero to the low byte, write the upper bytes, then write the low byte. The counter therefore never sees a half-written value, and a carry out of the low byte cannot spill into the upper bytes while the sequence is in progress.

Software reads the count one byte at a time from the live counter. If a second read of the low byte returns a smaller value than the first read, the count rolled over in between, and software reads again. An identification register returns a fixed subtype code.

Top module: `sec_counter_periph`

## Requirements
- R1: After reset the count is 0, the enable bit is 0, and the read data output is 0x00.
- R2: Control register at offset 0x46: bit 7 is the enable. A write stores bit 7 of the write data. A read returns the enable in bit 7 and 0 in bits 6..0.
- R3: While the enable is 1, each cycle with the tick high and no load adds exactly 1 to the count. While the enable is 0, or while the tick is low, the count does not change.
- R4: A tick at count 0xFFFFFFFF wraps the count to 0x00000000.
- R5: A write to offset 0x41, 0x42 or 0x43 stores the byte in staging byte 1, 2 or 3 and leaves the count untouched. Staging byte i reads back at offset 0x40+i.
- R6: A write of value v to offset 0x40 stores v in staging byte 0. On the same clock edge the count becomes {staging 3, staging 2, staging 1, v}, and any tick in that cycle is ignored.
- R7: A read strobe at offset 0x48+i captures byte i of the live count (byte 0 is least significant). The captured byte appears on the read data output one cycle later and stays there until the next read strobe.
- R8: A read of offset 0x05 returns the subtype code 0x01.
- R9: Reads of unmapped offsets return 0x00. Writes to read-only or unmapped offsets change neither the count, the enable nor the staging bytes.
- R10: The count output always equals the value returned by the four read-data byte offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, one cycle high |
| bus_addr_i | input | 8 | Register offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data byte |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, registered on the read strobe |
| count_o | output | 8*NB | Live seconds count for the alarm unit |

## Verification
The bench builds the block with the default of four count bytes, which gives a 32-bit counter. Because the time can be loaded directly, the bench can place the count at 0xFFFFFFFF and check the wrap without waiting billions of ticks. It can also place the low byte at 0xFF and confirm the carry that a second low-byte read reveals. Random mixes of writes, reads and ticks then check that a load overrides a tick arriving in the same cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  // Register offsets; the staging bank must end below the control offset.
  localparam logic [ADDR_W-1:0] OFS_ID    = 8'h05;
  localparam logic [ADDR_W-1:0] OFS_WBASE = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h46;
  localparam logic [ADDR_W-1:0] OFS_RBASE = 8'h48;
  localparam logic [DATA_W-1:0] SUBTYPE   = 8'h01;
  localparam int                EN_BIT    = 7;
endpackage

// File: rtl/sc_stage_bank.sv
module sc_stage_bank
  import sc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NB*DATA_W-1:0] stage_o,
  output logic                commit_o,
  output logic [NB*DATA_W-1:0] load_o
);
  localparam int W = NB * DATA_W;

  logic [W-1:0] stage_q;
  logic [W-1:0] stage_d;

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    logic hit;
    assign hit = wr_i && (addr_i == OFS_WBASE + ADDR_W'(gi));
    always_comb begin
      stage_d[gi*DATA_W +: DATA_W] = stage_q[gi*DATA_W +: DATA_W];
      if (hit) stage_d[gi*DATA_W +: DATA_W] = wdata_i;
    end
    if (gi == 0) begin : g_low
      assign load_o[DATA_W-1:0] = wdata_i;
    end else begin : g_up
      assign load_o[gi*DATA_W +: DATA_W] = stage_q[gi*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign stage_o  = stage_q;
  assign commit_o = wr_i && (addr_i == OFS_WBASE);
endmodule

// File: rtl/sc_count_core.sv
module sc_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         commit_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         adv;

  assign adv = en_i && tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (commit_i)  cnt_d = load_i;
    else if (adv)  cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !commit_i) |=> (count_o == $past(count_o) + W'(1))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en_i && tick_i) && !commit_i) |=> $stable(count_o)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !commit_i && (count_o == '1)) |=> (count_o == '0)); // R4
  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (count_o == $past(load_i))); // R6
endmodule

// File: rtl/sc_read_mux.sv
module sc_read_mux
  import sc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 en_i,
  input  logic [NB*DATA_W-1:0] stage_i,
  input  logic [NB*DATA_W-1:0] count_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] sel_d;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    sel_d = '0;
    if (addr_i == OFS_ID)   sel_d = SUBTYPE;
    if (addr_i == OFS_CTRL) sel_d[EN_BIT] = en_i;
    for (int i = 0; i < NB; i++) begin
      if (addr_i == OFS_WBASE + ADDR_W'(i)) sel_d = stage_i[i*DATA_W +: DATA_W];
      if (addr_i == OFS_RBASE + ADDR_W'(i)) sel_d = count_i[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_i) rdata_d = sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (addr_i == OFS_ID)) |=> (rdata_o == SUBTYPE)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o)); // R7
  AST_LOW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (addr_i == OFS_RBASE)) |=> (rdata_o == $past(count_i[DATA_W-1:0]))); // R7
endmodule

// File: rtl/sec_counter_periph.sv
module sec_counter_periph
  import sc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  input  logic                 bus_rd_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NB*DATA_W-1:0] count_o
);
  localparam int CW = NB * DATA_W;

  logic          en_q;
  logic          en_d;
  logic [CW-1:0] stage;
  logic [CW-1:0] load;
  logic [CW-1:0] count;
  logic          commit;

  always_comb begin
    en_d = en_q;
    if (bus_wr_i && (bus_addr_i == OFS_CTRL)) en_d = bus_wdata_i[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  sc_stage_bank #(.NB(NB)) i_stage (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .stage_o(stage), .commit_o(commit), .load_o(load)
  );

  sc_count_core #(.W(CW)) i_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_q),
    .commit_i(commit), .load_i(load), .count_o(count)
  );

  sc_read_mux #(.NB(NB)) i_rmux (
    .clk(clk), .rst_n(rst_n), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .en_i(en_q), .stage_i(stage), .count_i(count), .rdata_o(bus_rdata_o)
  );

  assign count_o = count;

  AST_UPPER_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && (bus_addr_i > OFS_WBASE) && (bus_addr_i < OFS_WBASE + ADDR_W'(NB))
     && !(en_q && tick_i)) |=> $stable(count_o)); // R5
  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(bus_wr_i && (bus_addr_i == OFS_WBASE))) |=> $stable(count_o)); // R3
endmodule

// File: tb/test_sec_counter_periph.sv
module test_sec_counter_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic        bus_rd_i = 1'b0;
  logic [7:0]  bus_rdata_o;
  logic [31:0] count_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_cnt;
  logic        m_en;
  logic [7:0]  m_stg [4];
  logic [7:0]  m_rd;

  always #2 clk = ~clk;

  sec_counter_periph #(.NB(4)) i_sec_counter_periph (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr_i(bus_addr_i),
    .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .bus_rd_i(bus_rd_i),
    .bus_rdata_o(bus_rdata_o), .count_o(count_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'h05) return 8'h01;
    if (a == 8'h46) return {m_en, 7'b0};
    if (a >= 8'h40 && a <= 8'h43) return m_stg[a - 8'h40];
    if (a >= 8'h48 && a <= 8'h4B) return m_cnt[(a - 8'h48) * 8 +: 8];
    return 8'h00;
  endfunction

  // One bus cycle: drive after a falling edge, check after the next falling edge.
  task automatic step(string tag, bit wr, bit rd, logic [7:0] a, logic [7:0] d, bit tk);
    logic [31:0] n_cnt;
    logic        n_en;
    logic [7:0]  n_rd;
    bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = d; tick_i = tk;
    n_cnt = m_cnt;
    if (wr && a == 8'h40) n_cnt = {m_stg[3], m_stg[2], m_stg[1], d};
    else if (m_en && tk)  n_cnt = m_cnt + 32'd1;
    n_en = (wr && a == 8'h46) ? d[7] : m_en;
    n_rd = rd ? exp_read(a) : m_rd;
    @(posedge clk);
    @(negedge clk);
    if (wr && a >= 8'h40 && a <= 8'h43) m_stg[a - 8'h40] = d;
    m_cnt = n_cnt; m_en = n_en; m_rd = n_rd;
    bus_wr_i = 1'b0; bus_rd_i = 1'b0; tick_i = 1'b0;
    chk({tag, " count"}, count_o, m_cnt);
    chk({tag, " rdata"}, {24'b0, bus_rdata_o}, {24'b0, m_rd});
  endtask

  task automatic load_time(logic [31:0] v);
    step("R6 clr", 1, 0, 8'h40, 8'h00, 0);
    step("R5 b1", 1, 0, 8'h41, v[15:8], 0);
    step("R5 b2", 1, 0, 8'h42, v[23:16], 0);
    step("R5 b3", 1, 0, 8'h43, v[31:24], 0);
    step("R6 commit", 1, 0, 8'h40, v[7:0], 1);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] first_lo;
    void'($urandom(32'hC0FFEE));
    m_cnt = '0; m_en = 1'b0; m_rd = '0;
    for (int i = 0; i < 4; i++) m_stg[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 count", count_o, 32'h0);
    chk("R1 rdata", {24'b0, bus_rdata_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1 enable clear", 0, 1, 8'h46, 8'h00, 1);
    step("R8 id", 0, 1, 8'h05, 8'h00, 0);
    step("R9 unmapped", 0, 1, 8'h47, 8'h00, 0);
    step("R3 disabled tick", 0, 0, 8'h00, 8'h00, 1);
    step("R2 enable", 1, 0, 8'h46, 8'hFF, 0);
    step("R2 readback", 0, 1, 8'h46, 8'h00, 0);
    step("R3 tick", 0, 0, 8'h00, 8'h00, 1);
    step("R3 no tick", 0, 0, 8'h00, 8'h00, 0);
    load_time(32'h1234_56FF);
    step("R5 stage read", 0, 1, 8'h42, 8'h00, 0);
    step("R7 low", 0, 1, 8'h48, 8'h00, 0);
    first_lo = bus_rdata_o;
    step("R3 tick", 0, 0, 8'h00, 8'h00, 1);
    step("R7 reread", 0, 1, 8'h48, 8'h00, 0);
    chk("R7 carry seen", {31'b0, bus_rdata_o < first_lo}, 32'h1);
    step("R7 byte1", 0, 1, 8'h49, 8'h00, 0);
    step("R9 ro write", 1, 0, 8'h49, 8'hAA, 0);
    step("R9 id write", 1, 0, 8'h05, 8'hAA, 0);
    step("R10 byte3", 0, 1, 8'h4B, 8'h00, 0);
    load_time(32'hFFFF_FFFF);
    step("R4 wrap", 0, 0, 8'h00, 8'h00, 1);
    step("R4 wrap read", 0, 1, 8'h4B, 8'h00, 0);
    step("R5 upper only", 1, 0, 8'h43, 8'h77, 0);
    step("R2 disable", 1, 0, 8'h46, 8'h7F, 0);
    step("R3 frozen", 0, 0, 8'h00, 8'h00, 1);
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      int sel;
      sel = int'($urandom % 8);
      case (sel)
        0, 1, 2, 3: a = 8'h40 + 8'($urandom % 4);
        4:          a = 8'h46;
        5:          a = 8'h48 + 8'($urandom % 4);
        6:          a = 8'h05;
        default:    a = 8'($urandom);
      endcase
      step("R10 random", ($urandom % 3) == 0, ($urandom % 2) == 0, a,
           8'($urandom) | ((sel == 4) ? 8'h80 : 8'h00), ($urandom % 2) == 1);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule